// File: doc/BRIEF.md
# Table-Driven Binary Logarithm Converter

This block turns an unsigned integer into a fixed-point estimate of its base-2 logarithm. It uses no adder or multiplier at run time. A priority encoder finds the position of the highest set bit, and that position becomes the integer part (the characteristic). A barrel shifter then moves the bits below that leading one up to the top of a fraction field. The upper bits of this fraction select one word from a constant table.

The range [1,2) of the mantissa is divided into equal-width regions. Each region keeps a single table word: the logarithm of the region's midpoint, rounded to the table word width. The table is computed inside the design at elaboration by an integer-only constant function, so no file is loaded. The result is the characteristic placed above the table word.

Three register stages form the datapath: encode, normalize, then table read. A valid bit travels beside the data, so a new operand can be accepted on every cycle. A zero operand has no logarithm, so it raises a flag and gives an all-zero result.

Top module: `log2_lut_conv`

## Requirements
- R1: For a nonzero operand, the characteristic field `out_log[CHAR_W+WORD_W-1:WORD_W]` equals the bit index of the most significant set bit of the operand.
- R2: The table address is the top `ADDR_W` bits of the bits below the leading one, left-aligned. Small operands are zero-filled at the low end, so the operand 1 addresses region 0.
- R3: The fraction field `out_log[WORD_W-1:0]` for region i is within one LSB of round(log2(1 + (2i+1)/2^(ADDR_W+1)) * 2^WORD_W). This holds for every i in 0 to 2^ADDR_W-1.
- R4: For any nonzero operand x, the value characteristic + fraction/2^WORD_W differs from log2(x) by less than 3.2e-3 (default parameters).
- R5: For an operand of zero, `out_zero` is 1 and `out_log` is all zeros in the result cycle. For any nonzero operand, `out_zero` is 0.
- R6: `out_valid` rises exactly three clock cycles after a cycle with `in_valid` high. It stays low three cycles after a cycle with `in_valid` low.
- R7: While `rst_n` is low, `out_valid`, `out_zero` and `out_log` are all 0.
- R8: Operands presented on consecutive cycles give results on consecutive cycles, in the same order, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_data | input | IN_W | Unsigned operand |
| out_valid | output | 1 | Result present this cycle |
| out_zero | output | 1 | Operand was zero |
| out_log | output | CHAR_W+WORD_W | Characteristic above the table word |

## Verification
Every result is due on the third rising edge after the edge that captures its operand. The bench drives on falling edges and reads on the falling edge after that third rising edge. It also confirms that `out_valid` is still low one edge earlier. In the streamed runs, the operand driven in loop step n is checked in step n+3, before the next operand is applied. This checks both the fixed latency and the order of results. Reference values are computed in real arithmetic in the bench, and the bench compares each one against the output at that sampling point.

// File: rtl/log2_lut_pkg.sv
package log2_lut_pkg;

    // Extra bits generated before rounding a table word.
    localparam int GUARD_BITS = 4;

    // log2 of the midpoint of region idx, rounded to word_w bits.
    // Uses repeated squaring of a Q30 value: after each squaring, a result
    // of 2 or more yields a one bit and a halving step.
    function automatic logic [31:0] log_entry(input int idx, input int addr_w, input int word_w);
        logic [63:0] x;
        logic [63:0] acc;
        logic [63:0] rnd;
        x   = (64'd1 << 30) + (64'(2 * idx + 1) << (29 - addr_w));
        acc = '0;
        for (int k = 0; k < word_w + GUARD_BITS; k++) begin
            x   = (x * x) >> 30;
            acc = acc << 1;
            if (x >= (64'd1 << 31)) begin
                acc = acc | 64'd1;
                x   = x >> 1;
            end
        end
        rnd = (acc + (64'd1 << (GUARD_BITS - 1))) >> GUARD_BITS;
        if (rnd >= (64'd1 << word_w)) begin
            rnd = (64'd1 << word_w) - 64'd1;
        end
        return rnd[31:0];
    endfunction

endpackage

// File: rtl/log2_msb_finder.sv
module log2_msb_finder #(
    parameter int IN_W   = 32,
    parameter int CHAR_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]   vec,
    output logic [CHAR_W-1:0] msb_idx,
    output logic [CHAR_W-1:0] lead_zeros,
    output logic              all_zero
);

    // Priority encoder: the highest set bit wins because it is visited last.
    // Both codes are constants per position, so no subtraction is needed.
    always_comb begin
        msb_idx    = '0;
        lead_zeros = '0;
        all_zero   = 1'b1;
        for (int i = 0; i < IN_W; i++) begin
            if (vec[i]) begin
                msb_idx    = CHAR_W'(i);
                lead_zeros = CHAR_W'(IN_W - 1 - i);
                all_zero   = 1'b0;
            end
        end
    end

endmodule

// File: rtl/log2_frac_normalizer.sv
module log2_frac_normalizer #(
    parameter int IN_W   = 32,
    parameter int FRAC_W = 26,
    parameter int CHAR_W = $clog2(IN_W)
) (
    input  logic [IN_W-2:0]   low_bits,
    input  logic [CHAR_W-1:0] shift,
    output logic [FRAC_W-1:0] frac
);

    // The leading one sits just above low_bits after this shift and is
    // dropped, so the bits under it are left-aligned.
    logic [IN_W-2:0] aligned;
    assign aligned = low_bits << shift;

    generate
        if (FRAC_W <= IN_W - 1) begin : g_trunc
            assign frac = aligned[IN_W-2 -: FRAC_W];
            if (FRAC_W < IN_W - 1) begin : g_drop
                logic unused_tail;
                assign unused_tail = ^aligned[IN_W-2-FRAC_W:0];
            end
        end else begin : g_fill
            assign frac = {aligned, {(FRAC_W - IN_W + 1){1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/log2_log_rom.sv
module log2_log_rom #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] rom_mem [DEPTH];

    // One constant word per region, computed at elaboration.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            localparam logic [31:0] RAW = log2_lut_pkg::log_entry(g, ADDR_W, WORD_W);
            assign rom_mem[g] = RAW[WORD_W-1:0];
        end
    endgenerate

    assign word = rom_mem[addr];

endmodule

// File: rtl/log2_lut_conv.sv
module log2_lut_conv #(
    parameter int IN_W   = 32,
    parameter int FRAC_W = 26,
    parameter int ADDR_W = 8,
    parameter int WORD_W = 12,
    parameter int CHAR_W = $clog2(IN_W)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [IN_W-1:0]          in_data,
    output logic                     out_valid,
    output logic                     out_zero,
    output logic [CHAR_W+WORD_W-1:0] out_log
);

    // Stage 1: encoded leading-one position plus the raw low bits.
    typedef struct packed {
        logic              v;
        logic              z;
        logic [CHAR_W-1:0] ch;
        logic [CHAR_W-1:0] lz;
        logic [IN_W-2:0]   low;
    } enc_st_t;

    // Stage 2: normalized fraction.
    typedef struct packed {
        logic              v;
        logic              z;
        logic [CHAR_W-1:0] ch;
        logic [FRAC_W-1:0] frac;
    } norm_st_t;

    // Stage 3: table word.
    typedef struct packed {
        logic              v;
        logic              z;
        logic [CHAR_W-1:0] ch;
        logic [WORD_W-1:0] word;
    } rd_st_t;

    typedef struct packed {
        enc_st_t  s1;
        norm_st_t s2;
        rd_st_t   s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [CHAR_W-1:0] enc_idx;
    logic [CHAR_W-1:0] enc_lz;
    logic              enc_zero;
    logic [FRAC_W-1:0] norm_frac;
    logic [WORD_W-1:0] rom_word;
    logic              unused_frac_low;

    log2_msb_finder #(.IN_W(IN_W), .CHAR_W(CHAR_W)) u_enc (
        .vec        (in_data),
        .msb_idx    (enc_idx),
        .lead_zeros (enc_lz),
        .all_zero   (enc_zero)
    );

    log2_frac_normalizer #(.IN_W(IN_W), .FRAC_W(FRAC_W), .CHAR_W(CHAR_W)) u_norm (
        .low_bits (pipe_q.s1.low),
        .shift    (pipe_q.s1.lz),
        .frac     (norm_frac)
    );

    log2_log_rom #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rom (
        .addr (pipe_q.s2.frac[FRAC_W-1 -: ADDR_W]),
        .word (rom_word)
    );

    // Fraction bits below the table address do not affect the result.
    generate
        if (FRAC_W > ADDR_W) begin : g_low
            assign unused_frac_low = ^pipe_q.s2.frac[FRAC_W-ADDR_W-1:0];
        end else begin : g_none
            assign unused_frac_low = 1'b0;
        end
    endgenerate

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.v   = in_valid;
        pipe_d.s1.z   = in_valid & enc_zero;
        pipe_d.s1.ch  = enc_idx;
        pipe_d.s1.lz  = enc_lz;
        pipe_d.s1.low = in_data[IN_W-2:0];

        pipe_d.s2.v    = pipe_q.s1.v;
        pipe_d.s2.z    = pipe_q.s1.z;
        pipe_d.s2.ch   = pipe_q.s1.z ? '0 : pipe_q.s1.ch;
        pipe_d.s2.frac = pipe_q.s1.z ? '0 : norm_frac;

        pipe_d.s3.v    = pipe_q.s2.v;
        pipe_d.s3.z    = pipe_q.s2.z;
        pipe_d.s3.ch   = pipe_q.s2.ch;
        pipe_d.s3.word = pipe_q.s2.z ? '0 : rom_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid = pipe_q.s3.v;
    assign out_zero  = pipe_q.s3.z;
    assign out_log   = {pipe_q.s3.ch, pipe_q.s3.word};

endmodule

// File: rtl/log2_lut_conv_chk.sv
module log2_lut_conv_chk #(
    parameter int IN_W   = 32,
    parameter int WORD_W = 12,
    parameter int CHAR_W = $clog2(IN_W)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [IN_W-1:0]          in_data,
    input logic                     out_valid,
    input logic                     out_zero,
    input logic [CHAR_W+WORD_W-1:0] out_log
);

    // R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R6
    idle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R5
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_zero == ($past(in_data, 3) == '0)));

    // R5
    zero_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_zero) |-> (out_log == '0));

    // R1
    char_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero) |->
            (($past(in_data, 3) >> out_log[CHAR_W+WORD_W-1:WORD_W]) == IN_W'(1)));

endmodule

bind log2_lut_conv log2_lut_conv_chk #(
    .IN_W   (IN_W),
    .WORD_W (WORD_W),
    .CHAR_W (CHAR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_zero  (out_zero),
    .out_log   (out_log)
);

// File: tb/log2_lut_conv_bench.sv
`timescale 1ns/1ps
module log2_lut_conv_bench;

    localparam int  IN_W   = 32;
    localparam int  FRAC_W = 26;
    localparam int  ADDR_W = 8;
    localparam int  WORD_W = 12;
    localparam int  CHAR_W = 5;
    localparam int  OUT_W  = CHAR_W + WORD_W;
    localparam real ERR_BOUND = 3.2e-3;

    // {expected characteristic, operand}
    localparam logic [36:0] VEC [12] = '{
        {5'd0,  32'h0000_0001},
        {5'd1,  32'h0000_0002},
        {5'd1,  32'h0000_0003},
        {5'd2,  32'h0000_0005},
        {5'd3,  32'h0000_000F},
        {5'd7,  32'h0000_00FF},
        {5'd8,  32'h0000_0100},
        {5'd9,  32'h0000_03E8},
        {5'd28, 32'h1234_5678},
        {5'd31, 32'hFFFF_FFFF},
        {5'd31, 32'h8000_0000},
        {5'd23, 32'h00AB_CDEF}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [IN_W-1:0]  in_data;
    logic             out_valid;
    logic             out_zero;
    logic [OUT_W-1:0] out_log;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] stim [256];

    always #2 clk = ~clk;

    log2_lut_conv #(
        .IN_W(IN_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
    ) u_log2_lut_conv (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_zero  (out_zero),
        .out_log   (out_log)
    );

    task automatic tally(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_char(input logic [31:0] x);
        int c = 0;
        for (int i = 0; i < IN_W; i++) if (x[i]) c = i;
        return c;
    endfunction

    function automatic int ref_region(input logic [31:0] x, input int c);
        longint unsigned v = 64'(x);
        return int'(((v - (64'd1 << c)) << ADDR_W) >> c);
    endfunction

    function automatic int ref_entry(input int r);
        real m = (2.0 * r + 1.0) / (2.0 ** (ADDR_W + 1));
        real l = $ln(1.0 + m) / $ln(2.0);
        return $rtoi(l * (2.0 ** WORD_W) + 0.5);
    endfunction

    // Compare the current outputs with the model for operand x.
    task automatic check_out(input logic [31:0] x, input int exp_c,
                             input string frac_req, input string valid_req);
        int  got_c, got_w, exp_w, dw;
        real val, truth, err;
        tally(out_valid == 1'b1, valid_req, "out_valid", out_valid, 1);
        if (x == 0) begin
            tally(out_zero == 1'b1, "R5", "out_zero", out_zero, 1);
            tally(out_log == '0, "R5", "out_log", out_log, 0);
        end else begin
            got_c = int'(out_log[OUT_W-1:WORD_W]);
            got_w = int'(out_log[WORD_W-1:0]);
            exp_w = ref_entry(ref_region(x, exp_c));
            dw    = got_w - exp_w;
            tally(out_zero == 1'b0, "R5", "out_zero", out_zero, 0);
            tally(got_c == exp_c, "R1", "characteristic", got_c, exp_c);
            tally(dw >= -1 && dw <= 1, frac_req, "table word", got_w, exp_w);
            val   = real'(got_c) + real'(got_w) / (2.0 ** WORD_W);
            truth = $ln(real'(x)) / $ln(2.0);
            err   = (val > truth) ? val - truth : truth - val;
            tally(err < ERR_BOUND, "R4", "abs error (1e-6 units)",
                  longint'($rtoi(err * 1.0e6)), longint'($rtoi(ERR_BOUND * 1.0e6)));
        end
    endtask

    // Back-to-back operands from stim[0..n-1]; item j checked in step j+3.
    task automatic run_stream(input int n, input string frac_req);
        for (int cyc = 0; cyc < n + 3; cyc++) begin
            @(negedge clk);
            if (cyc >= 3) check_out(stim[cyc-3], ref_char(stim[cyc-3]), frac_req, "R8");
            if (cyc < n) begin
                in_valid = 1'b1;
                in_data  = stim[cyc];
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
        end
        @(negedge clk);
        tally(out_valid == 1'b0, "R6", "out_valid after stream", out_valid, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b1;
        in_data  = 32'h0000_1234;
        repeat (4) @(negedge clk);
        // R7: reset holds outputs clear even with input activity
        tally(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
        tally(out_zero == 1'b0, "R7", "out_zero in reset", out_zero, 0);
        tally(out_log == '0, "R7", "out_log in reset", out_log, 0);
        in_valid = 1'b0;
        in_data  = '0;
        rst_n    = 1'b1;
        repeat (4) @(negedge clk);
        tally(out_valid == 1'b0, "R6", "idle out_valid", out_valid, 0);

        // Vector table, one operand at a time (R1, R2, R6)
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = VEC[i][31:0];
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = '0;
            @(negedge clk);
            tally(out_valid == 1'b0, "R6", "out_valid one cycle early", out_valid, 0);
            @(negedge clk);
            check_out(VEC[i][31:0], int'(VEC[i][36:32]), "R2", "R6");
        end

        // Zero operand (R5)
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = '0;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_out(32'd0, 0, "R5", "R6");

        // Every region with the full-width operand (R3)
        for (int i = 0; i < 256; i++) stim[i] = 32'h8000_0000 | (32'(i) << 23);
        run_stream(256, "R3");

        // Every region with a short operand, fraction zero-filled (R2)
        for (int i = 0; i < 256; i++) stim[i] = 32'h0000_0100 | 32'(i);
        run_stream(256, "R2");

        // Random operands of mixed magnitude, zeros included (R4, R8)
        for (int i = 0; i < 200; i++) stim[i] = $urandom() >> ($urandom() % 33);
        stim[17] = '0;
        run_stream(200, "R4");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule